// File: doc/BRIEF.md
# Memory-Mapped Machine Timer Unit

This block is a machine-level timer shared by several harts. It keeps one free-running 64-bit time counter, advanced by a tick-enable input, and one 64-bit compare value per hart. Each hart has its own interrupt line. That line is high whenever the hart's compare value is less than or equal to the counter.

Software reaches the registers through a simple request port: valid, write, size, address and write data. Read data and an error bit come back combinationally in the same cycle, and writes take effect at the next clock edge. Each register can be accessed as two 32-bit halves or, at an 8-byte aligned address, as one indivisible 64-bit word. The counter is writable. A counter write changes the interrupt condition of every hart in the same step as the new value lands.

Top module: `mtimer_unit`

## Requirements
- R1: `req_size`=1 selects an 8-byte access and `req_size`=0 a 4-byte access. An 8-byte access at an 8-byte aligned address reads or writes the whole 64-bit register in a single cycle.
- R2: The compare value of hart h sits at `CMP_BASE + 8*h`. Addresses from `CMP_BASE + 8*NUM_HARTS` upward do not belong to the compare array.
- R3: A 4-byte compare access at slot offset 0 touches only bits [31:0], and one at offset 4 touches only bits [63:32]. A write keeps the other half unchanged. A read returns the selected half in `rsp_rdata[31:0]` with `rsp_rdata[63:32]`=0.
- R4: An 8-byte access whose address has `addr[2:0]`!=0 sets `rsp_err`=1, writes nothing and reads zero. Every other access gives `rsp_err`=0.
- R5: The counter answers at `TIME_BASE` (low half for 4 bytes, whole word for 8 bytes) and at `TIME_BASE+4` (high half, 4 bytes only), with the same read format as R3.
- R6: A 4-byte counter write replaces only the addressed half and keeps the current value of the other half.
- R7: `timer_irq[h]` is 1 exactly when compare h is less than or equal to the counter, compared as unsigned 64-bit values. It follows a write to the counter or to a compare value in the same cycle that the written value appears.
- R8: The counter increments by one at each clock edge where `tick_en`=1. A counter write at the same edge wins over the increment. The carry crosses from bit 31 into bit 32.
- R9: After reset the counter is zero, every compare value is all ones, and every `timer_irq` bit is 0.
- R10: A 4-byte access with `addr[1:0]`!=0, and any access to an address outside the compare array and the counter's two words, reads zero and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter advance enable for this cycle |
| req_valid | input | 1 | Access request present |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 1 | 0 = 4 bytes, 1 = 8 bytes |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 64 | Write data (4-byte writes use bits [31:0]) |
| rsp_rdata | output | 64 | Read data, same cycle as the request |
| rsp_err | output | 1 | Misaligned 8-byte access |
| timer_irq | output | NUM_HARTS | Per-hart timer interrupt |

## Verification
The assertions assume that `TIME_BASE` and `CMP_BASE` are 8-byte aligned and that the counter window does not overlap the compare array. The stimulus uses only such parameter sets. The assertions also assume that request inputs are stable around the clock edge, so the bench drives them only on the falling edge.

The increment property assumes that `tick_en` is a clean level in the clock domain. The bench drives `tick_en` from the same falling-edge tasks, including cycles where it coincides with counter writes to exercise write priority.

// File: rtl/mtimer_pkg.sv
package mtimer_pkg;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_CMP  = 2'd1,
    TGT_TIME = 2'd2
  } tgt_e;

  typedef struct packed {
    tgt_e tgt;
    logic hi;
    logic wide;
    logic err;
  } dec_t;

  // Build the post-write value of a 64-bit register from its old value.
  function automatic logic [63:0] merge_word(input logic [63:0] old_v,
                                             input logic [63:0] wd,
                                             input logic        wide,
                                             input logic        hi);
    logic [63:0] r;
    if (wide)    r = wd;
    else if (hi) r = {wd[31:0], old_v[31:0]};
    else         r = {old_v[63:32], wd[31:0]};
    return r;
  endfunction

  // Format a 64-bit register for the read port.
  function automatic logic [63:0] view_word(input logic [63:0] v,
                                            input logic        wide,
                                            input logic        hi);
    logic [63:0] r;
    if (wide)    r = v;
    else if (hi) r = {32'd0, v[63:32]};
    else         r = {32'd0, v[31:0]};
    return r;
  endfunction

  function automatic logic is_due(input logic [63:0] cmp_v,
                                  input logic [63:0] now_v);
    return (cmp_v <= now_v);
  endfunction

endpackage

// File: rtl/mtimer_decode.sv
module mtimer_decode
  import mtimer_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter int                NUM_HARTS = 4,
  parameter int                HART_W    = 2,
  parameter logic [ADDR_W-1:0] CMP_BASE  = '0,
  parameter logic [ADDR_W-1:0] TIME_BASE = 16'h0040
) (
  input  logic              valid,
  input  logic              size8,
  input  logic [ADDR_W-1:0] addr,
  output dec_t              dec,
  output logic [HART_W-1:0] hart_idx
);

  localparam logic [ADDR_W:0] CMP_SPAN = (ADDR_W+1)'(NUM_HARTS * 8);
  localparam logic [ADDR_W:0] CMP_BASE_X = {1'b0, CMP_BASE};

  logic [ADDR_W:0] rel;
  logic            misaligned;
  logic            word_ok;
  logic            in_cmp;
  logic            in_time;

  always_comb begin
    rel        = {1'b0, addr} - CMP_BASE_X;
    misaligned = size8 && (addr[2:0] != 3'd0);
    word_ok    = (addr[1:0] == 2'd0);
    in_cmp     = (rel < CMP_SPAN);
    in_time    = (addr[ADDR_W-1:3] == TIME_BASE[ADDR_W-1:3]);
    hart_idx   = rel[3 +: HART_W];

    dec.hi   = addr[2];
    dec.wide = size8;
    dec.err  = valid && misaligned;
    dec.tgt  = TGT_NONE;
    if (valid && !misaligned && word_ok) begin
      if (in_cmp)       dec.tgt = TGT_CMP;
      else if (in_time) dec.tgt = TGT_TIME;
    end
  end

endmodule

// File: rtl/mtimer_counter.sv
module mtimer_counter #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         wr_en,
  input  logic [W-1:0] wr_value,
  output logic [W-1:0] now
);

  logic [W-1:0] now_q;

  always_ff @(posedge clk) begin
    if (!rst_n)       now_q <= '0;
    else if (wr_en)   now_q <= wr_value;
    else if (tick_en) now_q <= now_q + W'(1);
  end

  assign now = now_q;

  a_r8_tick_inc: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && tick_en) |=> (now_q == $past(now_q) + W'(1)));

  a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !tick_en) |=> $stable(now_q));

  a_r8_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (now_q == $past(wr_value)));

endmodule

// File: rtl/mtimer_cmp_slot.sv
module mtimer_cmp_slot
  import mtimer_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [63:0] wr_value,
  input  logic [63:0] now,
  output logic [63:0] cmp_q,
  output logic        irq
);

  always_ff @(posedge clk) begin
    if (!rst_n)     cmp_q <= '1;
    else if (wr_en) cmp_q <= wr_value;
  end

  assign irq = is_due(cmp_q, now);

  a_r3_slot_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cmp_q == $past(wr_value)));

  a_r7_rise_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> ($past(wr_en) || (now != $past(now))));

  a_r3_slot_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(cmp_q));

endmodule

// File: rtl/mtimer_unit.sv
module mtimer_unit
  import mtimer_pkg::*;
#(
  parameter int                NUM_HARTS = 4,
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] CMP_BASE  = '0,
  parameter logic [ADDR_W-1:0] TIME_BASE = 16'h0040
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic                 req_valid,
  input  logic                 req_write,
  input  logic                 req_size,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [63:0]          req_wdata,
  output logic [63:0]          rsp_rdata,
  output logic                 rsp_err,
  output logic [NUM_HARTS-1:0] timer_irq
);

  localparam int HART_W = (NUM_HARTS > 1) ? $clog2(NUM_HARTS) : 1;

  dec_t              dec;
  logic [HART_W-1:0] hart_idx;

  logic [63:0]          now_q;
  logic                 wr_time;
  logic [63:0]          time_next;
  logic [NUM_HARTS-1:0] cmp_we;
  logic [63:0]          cmp_val [NUM_HARTS];
  logic [63:0]          cmp_next [NUM_HARTS];
  logic                 do_write;

  mtimer_decode #(
    .ADDR_W   (ADDR_W),
    .NUM_HARTS(NUM_HARTS),
    .HART_W   (HART_W),
    .CMP_BASE (CMP_BASE),
    .TIME_BASE(TIME_BASE)
  ) decode_i (
    .valid   (req_valid),
    .size8   (req_size),
    .addr    (req_addr),
    .dec     (dec),
    .hart_idx(hart_idx)
  );

  assign do_write  = req_valid && req_write;
  assign wr_time   = do_write && (dec.tgt == TGT_TIME);
  assign time_next = merge_word(now_q, req_wdata, dec.wide, dec.hi);

  mtimer_counter #(.W(64)) counter_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .tick_en (tick_en),
    .wr_en   (wr_time),
    .wr_value(time_next),
    .now     (now_q)
  );

  for (genvar h = 0; h < NUM_HARTS; h++) begin : g_hart
    assign cmp_we[h]   = do_write && (dec.tgt == TGT_CMP) &&
                         (hart_idx == HART_W'(h));
    assign cmp_next[h] = merge_word(cmp_val[h], req_wdata, dec.wide, dec.hi);

    mtimer_cmp_slot slot_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (cmp_we[h]),
      .wr_value(cmp_next[h]),
      .now     (now_q),
      .cmp_q   (cmp_val[h]),
      .irq     (timer_irq[h])
    );
  end

  always_comb begin
    unique case (dec.tgt)
      TGT_CMP:  rsp_rdata = view_word(cmp_val[hart_idx], dec.wide, dec.hi);
      TGT_TIME: rsp_rdata = view_word(now_q, dec.wide, dec.hi);
      default:  rsp_rdata = '0;
    endcase
  end

  assign rsp_err = dec.err;

  a_r4_err_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (!wr_time && (cmp_we == '0)));

  a_r4_err_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == 64'd0));

  a_r2_single_slot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmp_we));

  a_r6_low_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_time && !req_size && !req_addr[2]) |=>
      (now_q[63:32] == $past(now_q[63:32])));

  a_r6_high_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_time && !req_size && req_addr[2]) |=>
      (now_q[31:0] == $past(now_q[31:0])));

  a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && (dec.tgt == TGT_NONE)) |-> (rsp_rdata == 64'd0));

endmodule

// File: tb/mtimer_unit_tb_top.sv
`timescale 1ns/1ps
module mtimer_unit_tb_top;

  localparam int          NH = 4;
  localparam logic [15:0] CB = 16'h0000;
  localparam logic [15:0] TB = 16'h0040;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_en = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic        req_size = 1'b0;
  logic [15:0] req_addr = '0;
  logic [63:0] req_wdata = '0;
  logic [63:0] rsp_rdata;
  logic        rsp_err;
  logic [NH-1:0] timer_irq;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [63:0] m_time;
  logic [63:0] m_cmp [NH];

  always #10 clk = ~clk;

  mtimer_unit #(.NUM_HARTS(NH), .ADDR_W(16), .CMP_BASE(CB), .TIME_BASE(TB)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .timer_irq(timer_irq)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // kind: 0 none, 1 compare slot, 2 counter
  task automatic classify(input int a, input bit wide, output int kind,
                          output int h, output bit hi);
    kind = 0; h = 0; hi = ((a % 8) == 4);
    if (wide && (a % 8) != 0) return;
    if ((a % 4) != 0) return;
    if (a >= int'(CB) && a < int'(CB) + NH * 8) begin
      kind = 1; h = (a - int'(CB)) / 8;
    end else if (a - (a % 8) == int'(TB)) begin
      kind = 2;
    end
  endtask

  function automatic logic [63:0] patch(input logic [63:0] old_v, input logic [63:0] d,
                                        input bit wide, input bit hi);
    logic [63:0] lo_mask = 64'hFFFF_FFFF;
    if (wide) return d;
    if (hi)   return ((d & lo_mask) << 32) + (old_v & lo_mask);
    return (old_v - (old_v & lo_mask)) + (d & lo_mask);
  endfunction

  task automatic access(input bit v, input bit w, input bit wide, input int a,
                        input logic [63:0] d, input bit tk, input string req);
    int kind; int h; bit hi;
    logic [63:0] val; logic [63:0] exp;
    bit exp_err;
    logic [NH-1:0] exp_irq;
    @(negedge clk);
    req_valid = v; req_write = w; req_size = wide; req_addr = 16'(a);
    req_wdata = d; tick_en = tk;
    #2;
    classify(a, wide, kind, h, hi);
    exp_err = v && wide && ((a % 8) != 0);
    for (int i = 0; i < NH; i++) exp_irq[i] = (m_cmp[i] <= m_time);
    chk("R7 irq", 64'(timer_irq), 64'(exp_irq));
    if (v) chk({req, " err R4"}, 64'(rsp_err), 64'(exp_err));
    if (v && !w) begin
      val = (kind == 1) ? m_cmp[h] : (kind == 2) ? m_time : 64'd0;
      if (kind == 0)  exp = 64'd0;
      else if (wide)  exp = val;
      else if (hi)    exp = val >> 32;
      else            exp = val & 64'hFFFF_FFFF;
      chk({req, " rdata"}, rsp_rdata, exp);
    end
    @(posedge clk);
    if (v && w && kind == 1) m_cmp[h] = patch(m_cmp[h], d, wide, hi);
    if (v && w && kind == 2) m_time = patch(m_time, d, wide, hi);
    else if (tk) m_time = m_time + 64'd1;
  endtask

  task automatic rd(input bit wide, input int a, input string req);
    access(1, 0, wide, a, 64'd0, 0, req);
  endtask

  task automatic wr(input bit wide, input int a, input logic [63:0] d, input string req);
    access(1, 1, wide, a, d, 0, req);
  endtask

  task automatic idle(input bit tk);
    access(0, 0, 0, 0, 64'd0, tk, "idle");
  endtask

  initial begin
    #(20 * 200000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    m_time = '0;
    for (int i = 0; i < NH; i++) m_cmp[i] = '1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R9 reset state
    rd(1, int'(TB), "R9 time after reset");
    for (int h = 0; h < NH; h++) rd(1, int'(CB) + h * 8, "R9 cmp after reset");

    // R1 R2 whole-word writes per hart
    for (int h = 0; h < NH; h++) begin
      wr(1, int'(CB) + h * 8, 64'h0123_4567_89AB_CDEF * 64'(h + 3), "R1 wide cmp write");
      rd(1, int'(CB) + h * 8, "R2 wide cmp read");
    end
    // R3 halves
    for (int h = 0; h < NH; h++) begin
      wr(0, int'(CB) + h * 8, 64'hDEAD_0000_0000_1000 + 64'(h), "R3 low write");
      rd(1, int'(CB) + h * 8, "R3 after low write");
      wr(0, int'(CB) + h * 8 + 4, 64'h5555_0000_7000_0000 + 64'(h), "R3 high write");
      rd(0, int'(CB) + h * 8 + 4, "R3 high read");
      rd(0, int'(CB) + h * 8, "R3 low read");
    end
    // R4 misaligned wide accesses
    wr(1, int'(CB) + 4, 64'hFFFF_FFFF_FFFF_FFFF, "R4 wide at +4");
    wr(1, int'(CB) + 10, 64'h0, "R4 wide at +2");
    wr(1, int'(TB) + 4, 64'h0, "R4 wide time +4");
    rd(1, int'(CB) + 4, "R4 misaligned read");
    rd(1, int'(CB), "R4 slot0 intact");
    rd(1, int'(TB), "R4 time intact");
    // R10 unmapped writes
    wr(1, int'(CB) + NH * 8, 64'h0, "R10 past array");
    wr(0, int'(CB) + 1, 64'h0, "R10 byte offset");
    wr(1, int'(TB) + 8, 64'h0, "R10 past time");
    for (int h = 0; h < NH; h++) rd(1, int'(CB) + h * 8, "R10 slot unchanged");

    // R5 R6 R8 counter writes, with ticks
    access(1, 1, 1, int'(TB), 64'h0000_0001_FFFF_FFF0, 1, "R8 write beats tick");
    rd(1, int'(TB), "R5 wide time read");
    access(1, 1, 0, int'(TB), 64'h0000_0000_FFFF_FFFE, 1, "R6 low write with tick");
    rd(0, int'(TB) + 4, "R6 high half kept");
    for (int i = 0; i < 4; i++) idle(1);
    rd(1, int'(TB), "R8 carry into high half");
    wr(0, int'(TB) + 4, 64'h0000_0000_0000_0007, "R6 high write");
    rd(0, int'(TB), "R6 low half kept");
    rd(0, int'(TB) + 4, "R5 high read");

    // R7 interrupt behaviour
    for (int h = 0; h < NH; h++) wr(1, int'(CB) + h * 8, 64'hFFFF_FFFF_FFFF_FFFF, "R7 park");
    wr(1, int'(TB), 64'd96, "R7 set time");
    wr(1, int'(CB), 64'd100, "R7 cmp0");
    wr(1, int'(CB) + 8, 64'd98, "R7 cmp1");
    for (int i = 0; i < 6; i++) idle(1);
    wr(1, int'(TB), 64'd10, "R7 time write clears");
    wr(0, int'(CB) + 16, 64'd10, "R7 cmp2 low equal");
    wr(0, int'(CB) + 16 + 4, 64'd0, "R7 cmp2 high zero");
    idle(0);
    wr(1, int'(TB), 64'hFFFF_FFFF_FFFF_FFFF, "R7 all due");
    idle(0);
    wr(1, int'(CB) + 24, 64'h8000_0000_0000_0000, "R7 unsigned compare");
    wr(1, int'(TB), 64'h7FFF_FFFF_FFFF_FFFF, "R7 time below");
    idle(1);
    idle(0);

    // R10 R4 R5 address sweep, both sizes
    for (int a = 0; a < int'(TB) + 24; a++) begin
      rd(0, a, "R10 sweep narrow");
      rd(1, a, "R10 sweep wide");
    end

    // R9 reset again in mid-run
    @(negedge clk); rst_n = 1'b0;
    @(posedge clk);
    m_time = '0;
    for (int i = 0; i < NH; i++) m_cmp[i] = '1;
    @(negedge clk); rst_n = 1'b1;
    rd(1, int'(TB), "R9 time after second reset");
    rd(1, int'(CB) + 8, "R9 cmp after second reset");
    idle(0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule